// File: doc/BRIEF.md
# Page Write Buffer with Self-Timed Programming Cycle

This block sits between a serial-memory protocol engine and a byte-wide storage array. The engine opens a page with a start address and then hands over data bytes one at a time. Each byte lands in a row latch at the current column. Only the column index advances, so a page that runs past the end of its row wraps back to column 0 of the same row, and the upper address bits never move. A column that is loaded twice keeps the later byte.

When the engine reports a valid commit, the block enters a programming cycle. Commit is signalled only for a stop condition in the slot straight after an acknowledge. During the cycle the block raises `busy` and walks the row latch one column per clock. It issues an array write for each loaded column only. The cycle ends when that walk is finished and a programmable write-time counter has expired. At the end it publishes the address just past the last byte loaded. An abort discards the latch. A page opened while write protection is high latches nothing and never starts a cycle. Physical programming is modelled as a plain RAM write strobe.

FSM states: `ST_IDLE` (waiting), `ST_LOAD` (page open, collecting bytes) and `ST_PROG` (programming cycle, `busy` high). Transitions:
- open: IDLE→LOAD on `load_start`.
- reopen: LOAD→LOAD on `load_start`.
- discard: LOAD→IDLE on `abort`.
- program: LOAD→PROG on `commit` when at least one byte is latched and the page is unprotected.
- drop: LOAD→IDLE on `commit` otherwise.
- finish: PROG→IDLE when both the column walk and the timer are done.

Top module: `pwb_page_writer`

## Requirements
- R1: After reset, `busy`, `arr_we` and `addr_upd` are 0 and `addr_out` is 0.
- R2: Bytes accepted after `load_start` go to consecutive columns. The first column is `start_addr[5:0]` and the row is `start_addr[15:6]`. After column 63 the next byte goes to column 0 of the same row.
- R3: While `busy` is high, the array is written one byte per clock, in ascending column order. Only loaded columns are written, each at address {row, column}.
- R4: When a column is loaded more than once within a page, the array receives the last byte given to it.
- R5: A `commit` in the LOAD state of an unprotected page holding at least one byte raises `busy` on the next clock.
- R6: `busy` stays high for exactly max(TW_CYCLES, 64) consecutive cycles.
- R7: `abort` discards the latched bytes. A following `commit`, and any `commit` outside the LOAD state, starts no cycle and causes no array write.
- R8: If `wr_protect` is 1 on the `load_start` clock, that page latches no bytes, and its `commit` starts no cycle and causes no array write.
- R9: While `busy` is high, `load_start`, `byte_valid`, `commit` and `abort` are ignored.
- R10: In the cycle `busy` falls, `addr_upd` pulses for one cycle. From then on `addr_out` holds {row, column after the last loaded byte}, using the 6-bit wrap. `addr_out` does not change at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_protect | input | 1 | Write protection, sampled when a page opens |
| load_start | input | 1 | Open a new page at `start_addr` |
| start_addr | input | 16 | Start byte address of the page |
| byte_valid | input | 1 | Data byte strobe |
| byte_data | input | 8 | Data byte |
| commit | input | 1 | Valid end of write: start programming |
| abort | input | 1 | Discard the open page |
| busy | output | 1 | Programming cycle in progress |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | 16 | Array write address |
| arr_wdata | output | 8 | Array write data |
| addr_out | output | 16 | Updated shared address counter value |
| addr_upd | output | 1 | One-cycle pulse when `addr_out` is updated |

## Verification
The bench builds the block with a 16-bit address, 64-byte rows and TW_CYCLES = 80 instead of a millisecond-scale count. This keeps every programming cycle to 80 clocks, so dozens of complete page writes fit into a short run. Because 80 exceeds the 64-column walk, the busy window is set by the timer, and its exact length can be checked. Full-row pages, wrapped pages and pages longer than one row are all reachable. This covers the wrap and last-byte-wins behaviour at both row edges.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } pwb_state_e;
endpackage

// File: rtl/pwb_row_latch.sv
module pwb_row_latch #(
    parameter int ADDR_W = 16,
    parameter int COL_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    open_i,
    input  logic [ADDR_W-1:0]       open_addr_i,
    input  logic                    clear_i,
    input  logic                    put_i,
    input  logic [DATA_W-1:0]       put_data_i,
    input  logic [COL_W-1:0]        rd_col_i,
    output logic [DATA_W-1:0]       rd_data_o,
    output logic                    rd_vld_o,
    output logic [ADDR_W-COL_W-1:0] row_o,
    output logic [COL_W-1:0]        col_o,
    output logic                    any_o
);
    localparam int PAGE = 1 << COL_W;

    logic [DATA_W-1:0]       page_q [PAGE];
    logic [PAGE-1:0]         mask_q;
    logic [ADDR_W-COL_W-1:0] row_q;
    logic [COL_W-1:0]        col_q;
    logic                    wr_now;

    assign wr_now = put_i && !open_i && !clear_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            row_q  <= '0;
            col_q  <= '0;
        end else if (open_i) begin
            mask_q <= '0;
            row_q  <= open_addr_i[ADDR_W-1:COL_W];
            col_q  <= open_addr_i[COL_W-1:0];
        end else if (clear_i) begin
            mask_q <= '0;
        end else if (put_i) begin
            mask_q[col_q] <= 1'b1;
            col_q         <= col_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_now) begin
            page_q[col_q] <= put_data_i;
        end
    end

    assign rd_data_o = page_q[rd_col_i];
    assign rd_vld_o  = mask_q[rd_col_i];
    assign row_o     = row_q;
    assign col_o     = col_q;
    assign any_o     = |mask_q;

    // R2: the column index wraps inside the row
    p_col_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_now && col_q == {COL_W{1'b1}}) |=> (col_q == '0));

    // R2: opening a page starts from an empty latch
    p_open_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        open_i |=> !any_o);
endmodule

// File: rtl/pwb_cycle_timer.sv
module pwb_cycle_timer #(
    parameter int TW_CYCLES = 625000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    localparam int CNT_W = $clog2(TW_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TW_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = run_i && (cnt_q == LAST);

    // R6: the counter never passes the write time
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/pwb_copy_scan.sv
module pwb_copy_scan #(
    parameter int COL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    output logic [COL_W-1:0] idx_o,
    output logic             active_o,
    output logic             last_o
);
    localparam logic [COL_W-1:0] TOP = {COL_W{1'b1}};

    logic [COL_W-1:0] idx_q;
    logic             fin_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            fin_q <= 1'b0;
        end else if (!run_i) begin
            idx_q <= '0;
            fin_q <= 1'b0;
        end else if (!fin_q) begin
            if (idx_q == TOP) fin_q <= 1'b1;
            else              idx_q <= idx_q + 1'b1;
        end
    end

    assign idx_o    = idx_q;
    assign active_o = run_i && !fin_q;
    assign last_o   = run_i && (fin_q || idx_q == TOP);

    // R3: one column per clock, ascending
    p_scan_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !fin_q && idx_q != TOP) |=> (!run_i || idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/pwb_page_writer.sv
module pwb_page_writer
    import pwb_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int COL_W     = 6,
    parameter int DATA_W    = 8,
    parameter int TW_CYCLES = 625000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_protect,
    input  logic              load_start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              commit,
    input  logic              abort,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic [ADDR_W-1:0] addr_out,
    output logic              addr_upd
);
    localparam int ROW_W = ADDR_W - COL_W;

    pwb_state_e        state_q, state_d;
    logic              prot_q;
    logic              open_c, clr_c, put_c;
    logic [DATA_W-1:0] rd_data;
    logic              rd_vld;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
    logic              any_vld;
    logic              tmr_done;
    logic [COL_W-1:0]  scan_idx;
    logic              scan_active, scan_last;
    logic [ADDR_W-1:0] addr_q;
    logic              upd_q;
    logic              in_prog;

    assign in_prog = (state_q == ST_PROG);

    pwb_row_latch #(.ADDR_W(ADDR_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_latch (
        .clk(clk), .rst_n(rst_n),
        .open_i(open_c), .open_addr_i(start_addr), .clear_i(clr_c),
        .put_i(put_c), .put_data_i(byte_data), .rd_col_i(scan_idx),
        .rd_data_o(rd_data), .rd_vld_o(rd_vld),
        .row_o(row), .col_o(col), .any_o(any_vld)
    );

    pwb_cycle_timer #(.TW_CYCLES(TW_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .run_i(in_prog), .done_o(tmr_done)
    );

    pwb_copy_scan #(.COL_W(COL_W)) u_scan (
        .clk(clk), .rst_n(rst_n), .run_i(in_prog),
        .idx_o(scan_idx), .active_o(scan_active), .last_o(scan_last)
    );

    // next state and latch controls
    always_comb begin
        state_d = state_q;
        open_c  = 1'b0;
        clr_c   = 1'b0;
        put_c   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (load_start) begin
                    open_c  = 1'b1;
                    state_d = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (load_start) begin
                    open_c = 1'b1;
                end else if (abort) begin
                    clr_c   = 1'b1;
                    state_d = ST_IDLE;
                end else if (commit) begin
                    state_d = (any_vld && !prot_q) ? ST_PROG : ST_IDLE;
                end else if (byte_valid && !prot_q) begin
                    put_c = 1'b1;
                end
            end
            ST_PROG: begin
                if (tmr_done && scan_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      prot_q <= 1'b0;
        else if (open_c) prot_q <= wr_protect;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            upd_q  <= 1'b0;
        end else begin
            upd_q <= 1'b0;
            if (in_prog && state_d == ST_IDLE) begin
                addr_q <= {row, col};
                upd_q  <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy      = in_prog;
        arr_we    = in_prog && scan_active && rd_vld;
        arr_addr  = {row, scan_idx};
        arr_wdata = rd_data;
        addr_out  = addr_q;
        addr_upd  = upd_q;
    end

    p_commit_starts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && commit && !load_start && !abort && any_vld && !prot_q) |=> busy);

    p_busy_until_timer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tmr_done) |=> busy);

    p_prot_no_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && prot_q) |=> !busy);

    p_row_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(row));

    p_upd_on_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        addr_upd |-> $fell(busy));
endmodule

// File: tb/tb_pwb_page_writer.sv
module tb_pwb_page_writer;
    localparam int AW = 16;
    localparam int CW = 6;
    localparam int DW = 8;
    localparam int TW = 80;
    localparam int PG = 1 << CW;
    localparam int RW = AW - CW;
    localparam int BUSY_LEN = (TW > PG) ? TW : PG;

    logic          clk, rst_n;
    logic          wr_protect, load_start, byte_valid, commit, abort;
    logic [AW-1:0] start_addr;
    logic [DW-1:0] byte_data;
    logic          busy, arr_we, addr_upd;
    logic [AW-1:0] arr_addr, addr_out;
    logic [DW-1:0] arr_wdata;

    pwb_page_writer #(.ADDR_W(AW), .COL_W(CW), .DATA_W(DW), .TW_CYCLES(TW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_protect(wr_protect), .load_start(load_start),
        .start_addr(start_addr), .byte_valid(byte_valid), .byte_data(byte_data),
        .commit(commit), .abort(abort), .busy(busy), .arr_we(arr_we),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata), .addr_out(addr_out), .addr_upd(addr_upd)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;

    // reference model
    logic [DW-1:0] m_data [PG];
    bit            m_mask [PG];
    logic [RW-1:0] m_row;
    logic [CW-1:0] m_col;
    bit            m_prot, m_open;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] g_data [PG];
    bit            g_mask [PG];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit model_any();
        for (int i = 0; i < PG; i++) if (m_mask[i]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [CW-1:0] next_col(input logic [CW-1:0] c);
        return c + 1'b1;
    endfunction

    task automatic quiet();
        load_start = 0; byte_valid = 0; commit = 0; abort = 0;
    endtask

    task automatic begin_page(input logic [AW-1:0] a, input bit wp);
        @(negedge clk);
        load_start = 1; start_addr = a; wr_protect = wp;
        @(negedge clk);
        load_start = 0; wr_protect = 0;
        m_open = 1; m_prot = wp;
        m_row = a[AW-1:CW]; m_col = a[CW-1:0];
        for (int i = 0; i < PG; i++) m_mask[i] = 0;
    endtask

    task automatic send_byte(input logic [DW-1:0] d);
        byte_valid = 1; byte_data = d;
        @(negedge clk);
        byte_valid = 0;
        if (m_open && !m_prot) begin
            m_data[m_col] = d;
            m_mask[m_col] = 1;
            m_col = next_col(m_col);
        end
    endtask

    task automatic do_abort();
        abort = 1;
        @(negedge clk);
        abort = 0;
        m_open = 0;
        for (int i = 0; i < PG; i++) m_mask[i] = 0;
    endtask

    task automatic do_commit(input bit noise, input string req_none);
        bit exp_cycle;
        int n, last, bad, ord_ok, row_ok;
        exp_cycle = m_open && !m_prot && model_any();
        commit = 1;
        @(negedge clk);
        commit = 0;
        if (exp_cycle) begin
            check(busy == 1, "R5", "busy after commit", busy, 1);
            for (int i = 0; i < PG; i++) g_mask[i] = 0;
            n = 0; last = -1; ord_ok = 1; row_ok = 1;
            while (busy && n < 10000) begin
                n++;
                if (arr_we) begin
                    if (int'(arr_addr[CW-1:0]) <= last) ord_ok = 0;
                    last = int'(arr_addr[CW-1:0]);
                    if (arr_addr[AW-1:CW] != m_row) row_ok = 0;
                    g_mask[arr_addr[CW-1:0]] = 1;
                    g_data[arr_addr[CW-1:0]] = arr_wdata;
                end
                if (noise) begin
                    load_start = 1'($urandom); byte_valid = 1'($urandom);
                    commit = 1'($urandom); abort = 1'($urandom);
                    start_addr = AW'($urandom); byte_data = DW'($urandom);
                end
                @(negedge clk);
            end
            quiet();
            check(n == BUSY_LEN, "R6", "busy length", n, BUSY_LEN);
            check(ord_ok == 1, "R3", "ascending single writes", ord_ok, 1);
            check(row_ok == 1, "R3", "write row", row_ok, 1);
            bad = 0;
            for (int i = 0; i < PG; i++) begin
                if (g_mask[i] != m_mask[i]) bad++;
                else if (m_mask[i] && g_data[i] != m_data[i]) bad++;
            end
            check(bad == 0, noise ? "R9" : "R4", "page image mismatches (R2)", bad, 0);
            m_addr = {m_row, m_col};
            check(addr_upd == 1, "R10", "addr_upd at busy fall", addr_upd, 1);
            check(addr_out == m_addr, "R10", "addr_out", addr_out, m_addr);
            @(negedge clk);
            check(addr_upd == 0, "R10", "addr_upd single pulse", addr_upd, 0);
        end else begin
            bad = 0;
            for (int k = 0; k < 4; k++) begin
                if (busy || arr_we) bad++;
                @(negedge clk);
            end
            check(bad == 0, req_none, "no cycle expected, busy/we seen", bad, 0);
            check(addr_out == m_addr, "R10", "addr_out unchanged", addr_out, m_addr);
        end
        m_open = 0;
    endtask

    initial begin
        #(8 * 190000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        quiet(); wr_protect = 0; start_addr = '0; byte_data = '0;
        m_open = 0; m_prot = 0; m_addr = '0; m_row = '0; m_col = '0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        check(busy == 0, "R1", "busy after reset", busy, 0);
        check(arr_we == 0, "R1", "arr_we after reset", arr_we, 0);
        check(addr_upd == 0, "R1", "addr_upd after reset", addr_upd, 0);
        check(addr_out == 0, "R1", "addr_out after reset", addr_out, 0);

        // R5, R2: single byte
        begin_page(16'h1234, 0);
        send_byte(8'hA5);
        do_commit(0, "R5");

        // R2: wrap from column 60
        begin_page(16'hBEFC, 0);
        for (int i = 0; i < 8; i++) send_byte(DW'(8'h10 + i));
        do_commit(0, "R2");

        // R4: longer than one row, overwrites
        begin_page(16'h0045, 0);
        for (int i = 0; i < 70; i++) send_byte(DW'(i * 3 + 1));
        do_commit(0, "R4");

        // R8: protected page
        begin_page(16'h2200, 1);
        for (int i = 0; i < 3; i++) send_byte(DW'(i));
        do_commit(0, "R8");

        // R7: abort then commit
        begin_page(16'h3310, 0);
        for (int i = 0; i < 4; i++) send_byte(DW'(8'hC0 + i));
        do_abort();
        do_commit(0, "R7");

        // R7: commit while idle
        do_commit(0, "R7");

        // R9: activity during busy
        begin_page(16'h7FC0, 0);
        for (int i = 0; i < 64; i++) send_byte(DW'($urandom));
        do_commit(1, "R9");

        // random pages
        for (int it = 0; it < 25; it++) begin
            logic [AW-1:0] a;
            bit wp;
            int cnt;
            a = AW'($urandom);
            wp = ($urandom % 5) == 0;
            cnt = 1 + int'($urandom % 70);
            begin_page(a, wp);
            for (int b = 0; b < cnt; b++) send_byte(DW'($urandom));
            if (($urandom % 6) == 0) do_abort();
            do_commit(it % 3 == 0, wp ? "R8" : "R7");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule